// File: doc/BRIEF.md
# Block-Paced Target Data-Phase Controller

This block sits on the core-logic side of a point-to-point graphics port and runs the data phases of one transaction at a time. For reads it moves words from a local queue onto the 32-bit AD bus. For writes it takes words off AD and hands them to a local sink. Flow control works on blocks of `BLOCK_PHASES` data phases, four by default, and not on single phases. The target strobe `trdy_n_o` (active low) marks the first phase of each block. Once a block has started it runs to its end with no pause. Wait states can only appear between blocks.

The master's active-low ready `irdy_n_i` works differently by direction. On a read, the first block never waits for the master. Each later block starts only after the master shows ready. On a write, the master's first ready commits it for the rest of the transaction, so later blocks wait only for local space. In the padded (wide) mode every block fills all of its phases. Phases beyond the requested length are filler: byte enables deasserted and AD driven to zero. In the plain mode the last block ends on the last real phase. During reads the parity line is driven whenever AD is driven, even though it carries no meaning.

Top module: `blkx_target`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `trdy_n_o` is 1, and none of `ad_oe_o`, `cbe_oe_o`, `par_oe_o`, `q_pop_o` or `wr_push_o` is asserted.
- R2: `start_i` is taken only when the block is idle and `len_i` is nonzero. A start with length zero leaves `busy_o` low. A start while busy does not change the transaction in progress.
- R3: A block starts only if `q_level_i` is at least the smaller of `BLOCK_PHASES` and the number of phases still to go. Until then `trdy_n_o` stays 1.
- R4: `trdy_n_o` is 0 for exactly one clock, the first data phase of each block. A transfer of at most `BLOCK_PHASES` phases gets one such clock.
- R5: On a read, the first block ignores `irdy_n_i`. Each later block needs `irdy_n_i` sampled 0 while the block is waiting.
- R6: On a write, the first block needs `irdy_n_i` sampled 0. Later blocks of the same transaction start whatever `irdy_n_i` does.
- R7: Conditions seen in a waiting cycle start the block on the next clock. The first `trdy_n_o` comes two clocks after `start_i` is sampled, and consecutive blocks are separated by at least one idle cycle.
- R8: Each real read phase pops the queue once and drives `ad_o` = `q_rdata_i` with `cbe_n_o` = 4'b0000. A read of N phases gives exactly N pops, in order.
- R9: With `wide_i` = 1 at start, every block takes `BLOCK_PHASES` clocks. Filler read phases drive `ad_o` = 0 and `cbe_n_o` = 4'b1111 and do not pop. Filler write phases do not push.
- R10: Whenever `ad_oe_o` is 1, `cbe_oe_o` and `par_oe_o` are 1 and `par_o` is the XOR of `ad_o` and `cbe_n_o` (even parity).
- R11: Each real write phase asserts `wr_push_o` with `wr_data_o` = `ad_i` and `wr_be_n_o` = `cbe_n_i`. During writes the AD, byte-enable and parity drivers are off.
- R12: `last_o` is 1 only in the last real data phase. `done_o` pulses once, in the final bus phase including filler, and `busy_o` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transaction |
| len_i | input | LEN_W | Transaction length in data phases |
| is_read_i | input | 1 | 1 = read (target returns data), 0 = write |
| wide_i | input | 1 | Padded block mode for this transaction |
| q_level_i | input | LVL_W | Words available (read) or free slots (write) in the local queue |
| q_rdata_i | input | DATA_W | Head word of the local read queue |
| q_pop_o | output | 1 | Consume the head word |
| wr_push_o | output | 1 | Write word valid |
| wr_data_o | output | DATA_W | Write word |
| wr_be_n_o | output | DATA_W/8 | Write byte enables, active low |
| irdy_n_i | input | 1 | Master ready, active low |
| trdy_n_o | output | 1 | Target block strobe, active low |
| ad_i | input | DATA_W | AD bus sampled |
| ad_o | output | DATA_W | AD bus driven |
| ad_oe_o | output | 1 | AD output enable |
| cbe_n_i | input | DATA_W/8 | Byte enables sampled |
| cbe_n_o | output | DATA_W/8 | Byte enables driven |
| cbe_oe_o | output | 1 | Byte-enable output enable |
| par_o | output | 1 | Parity driven |
| par_oe_o | output | 1 | Parity output enable |
| last_o | output | 1 | Last real data phase |
| done_o | output | 1 | Final bus phase of the transaction |
| busy_o | output | 1 | Transaction in progress |

## Verification
A wrong remaining-phase count shows up at the ports within the same transaction. The number of pops or pushes is off, `last_o` falls on the wrong phase, or `done_o` comes early or late, and in wide mode the filler count changes. A wrong position inside a block shows as a second `trdy_n_o` clock inside one block, or as a block that overruns into the next. A wrong record of master commitment or first-block status only shows in the wait between blocks. There it appears as a block that starts without the master's ready, or as a write that stalls after the master has committed. For that reason, each scenario holds `irdy_n_i` and `q_level_i` against the block for several cycles before releasing them.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_BURST = 2'd2
   } blkx_state_e;
endpackage

// File: rtl/blkx_seq.sv
module blkx_seq #(
   parameter int BLOCK_PHASES = 4,
   parameter int LEN_W        = 8,
   parameter int LVL_W        = 6,
   parameter int WIDE_OK      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             is_read_i,
   input  logic             wide_i,
   input  logic [LVL_W-1:0] q_level_i,
   input  logic             irdy_n_i,
   output logic             act_o,
   output logic             dat_ok_o,
   output logic             rd_o,
   output logic             trdy_n_o,
   output logic             last_o,
   output logic             done_o,
   output logic             busy_o
);
   import blkx_pkg::*;

   localparam int BPW = $clog2(BLOCK_PHASES);
   localparam int CW  = ((LEN_W > LVL_W) ? LEN_W : LVL_W) + 1;
   localparam logic [BPW-1:0]   BPOS_END = BPW'(BLOCK_PHASES - 1);
   localparam logic [LEN_W-1:0] BLK_LEN  = LEN_W'(BLOCK_PHASES);

   blkx_state_e      state_q, state_d;
   logic [LEN_W-1:0] rem_q, rem_d;
   logic [BPW-1:0]   bpos_q, bpos_d;
   logic             rd_q, rd_d;
   logic             wide_q, wide_d;
   logic             first_q, first_d;
   logic             commit_q, commit_d;

   logic             wide_sel;
   logic [LEN_W-1:0] need;
   logic             lvl_ok, master_ok, go;
   logic             dat_ok, blk_end, final_ph;
   logic [LEN_W-1:0] rem_next;

   // variant: padded mode present or fixed off
   generate
      if (WIDE_OK != 0) begin : g_wide
         assign wide_sel = wide_i;
      end else begin : g_narrow
         assign wide_sel = wide_i & 1'b0;
      end
   endgenerate

   assign need      = (rem_q >= BLK_LEN) ? BLK_LEN : rem_q;
   assign lvl_ok    = CW'(q_level_i) >= CW'(need);
   assign master_ok = rd_q ? (first_q || !irdy_n_i) : (commit_q || !irdy_n_i);
   assign go        = (state_q == ST_HOLD) && lvl_ok && master_ok;

   assign dat_ok   = (rem_q != '0);
   assign rem_next = dat_ok ? (rem_q - 1'b1) : rem_q;
   assign blk_end  = (bpos_q == BPOS_END) || (!wide_q && (rem_q == LEN_W'(1)));
   assign final_ph = blk_end && (rem_next == '0);

   always_comb begin
      state_d  = state_q;
      rem_d    = rem_q;
      bpos_d   = bpos_q;
      rd_d     = rd_q;
      wide_d   = wide_q;
      first_d  = first_q;
      commit_d = commit_q;
      case (state_q)
         ST_IDLE: begin
            if (start_i && (len_i != '0)) begin
               state_d  = ST_HOLD;
               rem_d    = len_i;
               rd_d     = is_read_i;
               wide_d   = wide_sel;
               first_d  = 1'b1;
               commit_d = 1'b0;
            end
         end
         ST_HOLD: begin
            if (go) begin
               state_d = ST_BURST;
               bpos_d  = '0;
               first_d = 1'b0;
               if (!rd_q) commit_d = 1'b1;
            end
         end
         ST_BURST: begin
            rem_d  = rem_next;
            bpos_d = bpos_q + 1'b1;
            if (blk_end) state_d = final_ph ? ST_IDLE : ST_HOLD;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         rem_q    <= '0;
         bpos_q   <= '0;
         rd_q     <= 1'b0;
         wide_q   <= 1'b0;
         first_q  <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         rem_q    <= rem_d;
         bpos_q   <= bpos_d;
         rd_q     <= rd_d;
         wide_q   <= wide_d;
         first_q  <= first_d;
         commit_q <= commit_d;
      end
   end

   assign act_o    = (state_q == ST_BURST);
   assign dat_ok_o = act_o && dat_ok;
   assign rd_o     = rd_q;
   assign trdy_n_o = !(act_o && (bpos_q == '0));
   assign last_o   = act_o && (rem_q == LEN_W'(1));
   assign done_o   = act_o && final_ph;
   assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/blkx_lanes.sv
module blkx_lanes #(
   parameter int DATA_W   = 32,
   parameter int PAR_EVEN = 1,
   localparam int BEW     = DATA_W / 8
) (
   input  logic              act_i,
   input  logic              dat_ok_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] q_rdata_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BEW-1:0]    cbe_n_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe_o,
   output logic [BEW-1:0]    cbe_n_o,
   output logic              cbe_oe_o,
   output logic              par_o,
   output logic              par_oe_o,
   output logic              q_pop_o,
   output logic              wr_push_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [BEW-1:0]    wr_be_n_o
);
   logic rd_phase, rd_data;
   logic par_raw;

   assign rd_phase = act_i && rd_i;
   assign rd_data  = rd_phase && dat_ok_i;

   assign ad_oe_o  = rd_phase;
   assign cbe_oe_o = rd_phase;
   assign par_oe_o = rd_phase;

   assign ad_o    = rd_data ? q_rdata_i : '0;
   assign cbe_n_o = rd_data ? '0 : '1;
   assign par_raw = ^{ad_o, cbe_n_o};

   generate
      if (PAR_EVEN != 0) begin : g_even
         assign par_o = par_raw;
      end else begin : g_odd
         assign par_o = ~par_raw;
      end
   endgenerate

   assign q_pop_o   = rd_data;
   assign wr_push_o = act_i && !rd_i && dat_ok_i;
   assign wr_data_o = ad_i;
   assign wr_be_n_o = cbe_n_i;
endmodule

// File: rtl/blkx_target.sv
module blkx_target #(
   parameter int DATA_W       = 32,
   parameter int BLOCK_PHASES = 4,
   parameter int LEN_W        = 8,
   parameter int LVL_W        = 6,
   parameter int WIDE_OK      = 1,
   parameter int PAR_EVEN     = 1,
   localparam int BEW         = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              is_read_i,
   input  logic              wide_i,
   input  logic [LVL_W-1:0]  q_level_i,
   input  logic [DATA_W-1:0] q_rdata_i,
   output logic              q_pop_o,
   output logic              wr_push_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [BEW-1:0]    wr_be_n_o,
   input  logic              irdy_n_i,
   output logic              trdy_n_o,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe_o,
   input  logic [BEW-1:0]    cbe_n_i,
   output logic [BEW-1:0]    cbe_n_o,
   output logic              cbe_oe_o,
   output logic              par_o,
   output logic              par_oe_o,
   output logic              last_o,
   output logic              done_o,
   output logic              busy_o
);
   generate
      if (BLOCK_PHASES < 2 || (BLOCK_PHASES & (BLOCK_PHASES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_PHASES must be a power of two, at least 2");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if ((1 << LEN_W) <= BLOCK_PHASES) begin : g_bad_len
         $error("LEN_W too narrow to hold one block");
      end
      if ((1 << LVL_W) <= BLOCK_PHASES) begin : g_bad_lvl
         $error("LVL_W too narrow to report one block");
      end
   endgenerate

   logic act, dat_ok, rd;

   blkx_seq #(
      .BLOCK_PHASES(BLOCK_PHASES),
      .LEN_W       (LEN_W),
      .LVL_W       (LVL_W),
      .WIDE_OK     (WIDE_OK)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .len_i    (len_i),
      .is_read_i(is_read_i),
      .wide_i   (wide_i),
      .q_level_i(q_level_i),
      .irdy_n_i (irdy_n_i),
      .act_o    (act),
      .dat_ok_o (dat_ok),
      .rd_o     (rd),
      .trdy_n_o (trdy_n_o),
      .last_o   (last_o),
      .done_o   (done_o),
      .busy_o   (busy_o)
   );

   blkx_lanes #(
      .DATA_W  (DATA_W),
      .PAR_EVEN(PAR_EVEN)
   ) u_lanes (
      .act_i    (act),
      .dat_ok_i (dat_ok),
      .rd_i     (rd),
      .q_rdata_i(q_rdata_i),
      .ad_i     (ad_i),
      .cbe_n_i  (cbe_n_i),
      .ad_o     (ad_o),
      .ad_oe_o  (ad_oe_o),
      .cbe_n_o  (cbe_n_o),
      .cbe_oe_o (cbe_oe_o),
      .par_o    (par_o),
      .par_oe_o (par_oe_o),
      .q_pop_o  (q_pop_o),
      .wr_push_o(wr_push_o),
      .wr_data_o(wr_data_o),
      .wr_be_n_o(wr_be_n_o)
   );
endmodule

// File: rtl/blkx_target_chk.sv
module blkx_target_chk #(
   parameter int LVL_W = 6,
   parameter int BEW   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] q_level_i,
   input logic             q_pop_o,
   input logic             wr_push_o,
   input logic             trdy_n_o,
   input logic             ad_oe_o,
   input logic [BEW-1:0]   cbe_n_o,
   input logic             cbe_oe_o,
   input logic             par_oe_o,
   input logic             done_o,
   input logic             busy_o
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (trdy_n_o && !ad_oe_o && !q_pop_o && !wr_push_o));

   assert_level_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trdy_n_o) |-> ($past(q_level_i) != '0));

   assert_trdy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n_o |=> trdy_n_o);

   assert_trdy_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n_o |-> busy_o);

   assert_pop_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop_o |-> (ad_oe_o && (cbe_n_o == '0)));

   assert_par_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe_o |-> (par_oe_o && cbe_oe_o));

   assert_write_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_push_o |-> (!ad_oe_o && !cbe_oe_o && !q_pop_o));

   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
endmodule

bind blkx_target blkx_target_chk #(.LVL_W(LVL_W), .BEW(BEW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .q_level_i(q_level_i),
   .q_pop_o  (q_pop_o),
   .wr_push_o(wr_push_o),
   .trdy_n_o (trdy_n_o),
   .ad_oe_o  (ad_oe_o),
   .cbe_n_o  (cbe_n_o),
   .cbe_oe_o (cbe_oe_o),
   .par_oe_o (par_oe_o),
   .done_o   (done_o),
   .busy_o   (busy_o)
);

// File: tb/blkx_target_tb.sv
module blkx_target_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  len_i = '0;
   logic        is_read_i = 1'b0;
   logic        wide_i = 1'b0;
   logic [5:0]  q_level_i = '0;
   logic [31:0] q_rdata_i;
   logic        q_pop_o, wr_push_o;
   logic [31:0] wr_data_o;
   logic [3:0]  wr_be_n_o;
   logic        irdy_n_i = 1'b1;
   logic        trdy_n_o;
   logic [31:0] ad_i = '0;
   logic [31:0] ad_o;
   logic        ad_oe_o;
   logic [3:0]  cbe_n_i = '1;
   logic [3:0]  cbe_n_o;
   logic        cbe_oe_o, par_o, par_oe_o, last_o, done_o, busy_o;

   int n_chk = 0, n_err = 0;
   logic [31:0] rd_idx;

   always #10 clk = ~clk;

   // local read queue model: head word follows pop count
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rd_idx <= '0;
      else if (q_pop_o) rd_idx <= rd_idx + 1;
   assign q_rdata_i = 32'hA000_0000 + rd_idx;

   blkx_target u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .is_read_i(is_read_i), .wide_i(wide_i), .q_level_i(q_level_i),
      .q_rdata_i(q_rdata_i), .q_pop_o(q_pop_o), .wr_push_o(wr_push_o),
      .wr_data_o(wr_data_o), .wr_be_n_o(wr_be_n_o), .irdy_n_i(irdy_n_i),
      .trdy_n_o(trdy_n_o), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
      .cbe_n_i(cbe_n_i), .cbe_n_o(cbe_n_o), .cbe_oe_o(cbe_oe_o),
      .par_o(par_o), .par_oe_o(par_oe_o), .last_o(last_o),
      .done_o(done_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // results of one transaction
   int n_trdy, n_trdy_pre, t1, t2, n_pop, n_push, n_fill, n_phase;
   int n_last, last_cyc, last_x, n_done, done_cyc, bad_data, bad_par, bad_hiz;
   bit busy_after, hung;

   task automatic run_xfer(input int len, input bit rd, input bit wide,
                           input int lvl_lo, input int lvl_at,
                           input int irdy_lo_at, input int irdy_hi_at,
                           input int restart_at);
      int gate;
      bit fin, done_seen;
      gate = (lvl_at > irdy_lo_at) ? lvl_at : irdy_lo_at;
      n_trdy = 0; n_trdy_pre = 0; t1 = -1; t2 = -1; n_pop = 0; n_push = 0;
      n_fill = 0; n_phase = 0; n_last = 0; last_cyc = -1; last_x = -2;
      n_done = 0; done_cyc = -1; bad_data = 0; bad_par = 0; bad_hiz = 0;
      busy_after = 1'b1; hung = 1'b0; fin = 1'b0; done_seen = 1'b0;
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
         @(negedge clk);
         start_i   = (cyc == 0) || (cyc == restart_at);
         len_i     = (cyc == 0) ? 8'(len) : 8'd3;
         is_read_i = rd;
         wide_i    = wide;
         q_level_i = (cyc < lvl_at) ? 6'(lvl_lo) : 6'd20;
         irdy_n_i  = !(cyc >= irdy_lo_at && cyc < irdy_hi_at);
         ad_i      = 32'h5000_0000 + 32'(cyc);
         cbe_n_i   = 4'(cyc);
         #1;
         if (done_seen) begin
            busy_after = busy_o;
            fin = 1'b1;
         end else begin
            if (!trdy_n_o) begin
               n_trdy++;
               if (cyc < gate) n_trdy_pre++;
               if (n_trdy == 1) t1 = cyc;
               if (n_trdy == 2) t2 = cyc;
            end
            if (ad_oe_o) begin
               n_phase++;
               if (!par_oe_o || !cbe_oe_o || par_o != ^{ad_o, cbe_n_o}) bad_par++;
            end
            if (q_pop_o) begin
               n_pop++; last_x = cyc;
               if (ad_o != 32'hA000_0000 + rd_idx || cbe_n_o != 4'h0) bad_data++;
            end else if (ad_oe_o) begin
               n_fill++;
               if (ad_o != 32'h0 || cbe_n_o != 4'hF) bad_data++;
            end
            if (wr_push_o) begin
               n_push++; last_x = cyc;
               if (wr_data_o != ad_i || wr_be_n_o != cbe_n_i) bad_data++;
            end
            if (!rd && (ad_oe_o || cbe_oe_o || par_oe_o || q_pop_o)) bad_hiz++;
            if (rd && wr_push_o) bad_hiz++;
            if (last_o) begin n_last++; last_cyc = cyc; end
            if (done_o) begin n_done++; done_cyc = cyc; done_seen = 1'b1; end
         end
      end
      if (!fin) hung = 1'b1;
      @(negedge clk);
      start_i = 1'b0; irdy_n_i = 1'b1; q_level_i = '0;
   endtask

   task automatic common(input string req, input int len, input bit rd, input int trdys);
      chk(!hung, req, "transaction completes", hung, 0);
      chk((rd ? n_pop : n_push) == len, req, "words moved", rd ? n_pop : n_push, len);
      chk(n_trdy == trdys, "R4", "trdy clocks", n_trdy, trdys);
      chk(bad_data == 0, rd ? "R8" : "R11", "data/byte-enable errors", bad_data, 0);
      chk(bad_par == 0, "R10", "parity/enable errors", bad_par, 0);
      chk(bad_hiz == 0, "R11", "direction driver errors", bad_hiz, 0);
      chk(n_last == 1 && last_cyc == last_x, "R12", "last flag on final word", last_cyc, last_x);
      chk(n_done == 1 && !busy_after, "R12", "single done then idle", n_done, 1);
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && trdy_n_o && !ad_oe_o && !cbe_oe_o && !par_oe_o
          && !q_pop_o && !wr_push_o, "R1", "reset state quiet", busy_o, 0);
   endtask

   task automatic t_zero_len();
      bit seen;
      seen = 1'b0;
      @(negedge clk); start_i = 1'b1; len_i = 8'd0; is_read_i = 1'b1; q_level_i = 6'd20;
      @(negedge clk); start_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
         #1; if (busy_o || !trdy_n_o) seen = 1'b1;
         @(negedge clk);
      end
      chk(!seen, "R2", "zero length start ignored", seen, 0);
      q_level_i = '0;
   endtask

   task automatic t_short_read();
      run_xfer(3, 1, 0, 20, 0, 1000, 1000, -1);
      common("R5", 3, 1, 1);
      chk(t1 == 2, "R7", "first trdy two clocks after start", t1, 2);
   endtask

   task automatic t_long_read_irdy();
      run_xfer(10, 1, 0, 20, 0, 12, 1000, 8);
      common("R2", 10, 1, 3);
      chk(n_trdy_pre == 1, "R5", "only initial block before master ready", n_trdy_pre, 1);
      chk(t2 == 13, "R5", "second block after master ready", t2, 13);
   endtask

   task automatic t_back_to_back();
      run_xfer(8, 1, 0, 20, 0, 0, 1000, -1);
      common("R8", 8, 1, 2);
      chk(t1 == 2 && t2 == 7, "R7", "one idle clock between blocks", t2, 7);
      chk(done_cyc == 10, "R12", "done cycle", done_cyc, 10);
   endtask

   task automatic t_level_gate();
      run_xfer(6, 1, 0, 3, 10, 0, 1000, -1);
      common("R3", 6, 1, 2);
      chk(n_trdy_pre == 0, "R3", "no block while level short", n_trdy_pre, 0);
      chk(t1 == 11, "R3", "block after level sufficient", t1, 11);
      run_xfer(2, 1, 0, 2, 1000, 0, 1000, -1);
      common("R3", 2, 1, 1);
   endtask

   task automatic t_wide_read();
      run_xfer(6, 1, 1, 20, 0, 0, 1000, -1);
      common("R9", 6, 1, 2);
      chk(n_phase == 8 && n_fill == 2, "R9", "filler phases", n_fill, 2);
      chk(done_cyc == 10, "R9", "done at end of padded block", done_cyc, 10);
   endtask

   task automatic t_write();
      run_xfer(10, 0, 0, 20, 0, 4, 7, -1);
      common("R6", 10, 0, 3);
      chk(n_trdy_pre == 0, "R6", "write waits for master ready", n_trdy_pre, 0);
      chk(t1 == 5, "R6", "first write block timing", t1, 5);
   endtask

   task automatic t_wide_write();
      run_xfer(5, 0, 1, 20, 0, 0, 1000, -1);
      common("R11", 5, 0, 2);
      chk(done_cyc == 10, "R9", "write padded to full block", done_cyc, 10);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "WATCHDOG", "run finished", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1; t_reset();
      rst_n = 1'b1;
      t_zero_len();
      t_short_read();
      t_long_read_irdy();
      t_back_to_back();
      t_level_gate();
      t_wide_read();
      t_write();
      t_wide_write();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule